// File: doc/BRIEF.md
# Parallel LCD Host Bus Front End

This block sits between a host processor's parallel bus and the display memory of an LCD controller. It accepts bus cycles in either of two styles: separate active-low write and read strobes, or a read/write select qualified by an active-high enable. The bus can be 8 bits wide or, to save pins, 4 bits wide. In the 4-bit case every byte crosses as two nibbles, most significant first. A command/data pin decides whether a cycle carries a command or touches display memory.

Command bytes leave as a one-cycle command stream. Two of them, set-column and set-row, are also decoded here because they move the memory pointer. Data writes go to display memory in the cycle the write strobe is released, with no buffering. Data reads come from a two-stage read pipeline. After the pointer is set, the first data read only primes that pipeline and returns filler. Every committed data write and every real data read steps the column, and the column carries into the row.

All bus pins are treated as synchronous to `clk` and are sampled by it. Strobe releases are found by comparing each pin with its value from the previous clock cycle.

Top module: `lcd_host_bus`

## Requirements
- R1: With `busMode`=0, a cycle is taken when `csN` is low and the active-low `wrN` (write) or `rdN` (read) is released. Write outputs are valid in the cycle of the release. While `rdN` is low and `csN` is low, `dataOe` is 1 and `dataOut` carries the read byte.
- R2: With `busMode`=1, `enable`=1 marks a cycle, `rwSel`=0 means write and `rwSel`=1 means read, and the cycle is taken when `enable` falls. Data and addressing behave as in R1.
- R3: While `csN` is high, strobes have no effect: there is no `ramWe`, no `cmdValid`, `dataOe` stays 0 and the memory pointer does not move.
- R4: A completed write byte with `cd`=0 pulses `cmdValid` with the byte on `cmdByte`. With `cd`=1 it pulses `ramWe` with the byte on `ramWdata` at the current `ramCol`/`ramRow`. The two never occur together.
- R5: With `nibbleMode`=1, the nibble is taken from `dataIn[3:0]`. The first strobe of a byte carries bits 7:4, the second carries bits 3:0, and the byte takes effect only on the second strobe.
- R6: While `csN` is low, a change of `cd` returns the nibble phase to the high nibble. If the change falls in the same cycle as a strobe release, that nibble is treated as the high nibble.
- R7: Command 0x1n loads column n and command 0x2n loads row n. Both leave the read pipeline unprimed.
- R8: The first data read after reset or after R7 is a dummy: it returns filler and does not move the pointer. Each later data read returns the memory byte at the current pointer and then steps the pointer.
- R9: With `nibbleMode`=1, reads drive the high nibble and then the low nibble on `dataOut[3:0]`, with `dataOut[7:4]`=0. The dummy read takes two nibble strobes.
- R10: Each committed data write and each non-dummy data read adds one to the column. Column `COLS-1` wraps to 0 and adds one to the row, which wraps after `ROWS-1`.
- R11: `rstN` low sets the nibble phase to the high nibble, the pointer to column 0 and row 0, and the pipeline to unprimed.
- R12: A read with `cd`=0 returns `statusIn`, split into nibbles as in R9 when `nibbleMode`=1, and leaves the pointer and the pipeline unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busMode | input | 1 | 0 = separate write/read strobes, 1 = read/write select plus enable |
| nibbleMode | input | 1 | 0 = 8-bit bus, 1 = 4-bit bus on dataIn[3:0]/dataOut[3:0] |
| csN | input | 1 | Active-low chip select |
| cd | input | 1 | 0 = command write or status read, 1 = display memory access |
| wrN | input | 1 | Active-low write strobe (busMode 0) |
| rdN | input | 1 | Active-low read strobe (busMode 0) |
| rwSel | input | 1 | 1 = read, 0 = write (busMode 1) |
| enable | input | 1 | Active-high cycle enable (busMode 1) |
| dataIn | input | 8 | Bus write data |
| dataOut | output | 8 | Bus read data |
| dataOe | output | 1 | High while a selected read strobe is active |
| statusIn | input | 8 | Status byte returned on command-side reads |
| cmdValid | output | 1 | One-cycle pulse for each completed command byte |
| cmdByte | output | 8 | Command byte, valid with cmdValid |
| ramWe | output | 1 | One-cycle display memory write request |
| ramWdata | output | 8 | Display memory write data |
| ramCol | output | $clog2(COLS) | Current column pointer |
| ramRow | output | $clog2(ROWS) | Current row pointer |
| ramRdata | input | 8 | Display memory read data at ramCol/ramRow (combinational) |

## Verification
The risky overlap is a change of `cd` in the same clock cycle as the release of a 4-bit strobe. Both the phase reset and the nibble completion want to update the nibble phase at once. The bench sets this up by latching a high nibble and then, on the next strobe, releasing `wrN` and flipping `cd` at the same clock edge. It then checks that nothing committed and that only the next strobe completed a command byte made from the two later nibbles. Near-exhaustive pointer sweeps also land a column wrap on the same commit as a row step, and these are compared against addresses computed in the bench.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  // Control-to-datapath strobes, one cycle each unless noted.
  typedef struct packed {
    logic hiStore;   // latch high nibble of a 4-bit write
    logic byteWrite; // a full write byte completes this cycle
    logic isData;    // cd level for the current cycle
    logic advance;   // step the memory pointer
    logic reload;    // refill the read register from memory
    logic phaseLo;   // registered nibble phase (1 = low nibble next)
  } bus_strobe_t;
endpackage

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busMode,
  input  logic        nibbleMode,
  input  logic        csN,
  input  logic        cd,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        rwSel,
  input  logic        enable,
  input  logic        addrSet,
  output bus_strobe_t strobes,
  output logic        dataOe
);
  logic wrAct, rdAct, wrPrev, rdPrev, cdPrev;
  logic phase, primed, reloadQ;
  logic sel, wrDone, rdDone, anyDone, cdFlip, effPhase;
  logic byteDone, dataWr, dataRd, phaseNext;

  always_comb begin
    wrAct     = busMode ? (enable & ~rwSel) : ~wrN;
    rdAct     = busMode ? (enable & rwSel) : ~rdN;
    sel       = ~csN;
    wrDone    = sel & wrPrev & ~wrAct;
    rdDone    = sel & rdPrev & ~rdAct;
    anyDone   = wrDone | rdDone;
    cdFlip    = sel & (cd ^ cdPrev);
    effPhase  = cdFlip ? 1'b0 : phase;
    byteDone  = anyDone & (~nibbleMode | effPhase);
    dataWr    = wrDone & byteDone & cd;
    dataRd    = rdDone & byteDone & cd;
    if (!nibbleMode)
      phaseNext = 1'b0;
    else if (anyDone)
      phaseNext = ~effPhase;
    else
      phaseNext = effPhase;
  end

  always_comb begin
    strobes.hiStore   = wrDone & nibbleMode & ~effPhase;
    strobes.byteWrite = wrDone & byteDone;
    strobes.isData    = cd;
    strobes.advance   = dataWr | (dataRd & primed);
    strobes.reload    = reloadQ;
    strobes.phaseLo   = phase;
    dataOe            = sel & rdAct;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      rdPrev  <= 1'b0;
      cdPrev  <= 1'b0;
      phase   <= 1'b0;
      primed  <= 1'b0;
      reloadQ <= 1'b0;
    end else begin
      wrPrev  <= wrAct;
      rdPrev  <= rdAct;
      cdPrev  <= cd;
      phase   <= phaseNext;
      reloadQ <= dataWr | dataRd;
      if (addrSet)
        primed <= 1'b0;
      else if (dataRd)
        primed <= 1'b1;
    end
  end
endmodule

// File: rtl/lcd_bus_datapath.sv
module lcd_bus_datapath
  import lcd_bus_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 104,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bus_strobe_t      strobes,
  input  logic             nibbleMode,
  input  logic [7:0]       dataIn,
  input  logic [7:0]       statusIn,
  input  logic [7:0]       ramRdata,
  output logic [7:0]       dataOut,
  output logic             cmdValid,
  output logic [7:0]       cmdByte,
  output logic             ramWe,
  output logic [7:0]       ramWdata,
  output logic [COL_W-1:0] ramCol,
  output logic [ROW_W-1:0] ramRow,
  output logic             addrSet
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [3:0] hiNib;
  logic [7:0] assembled, readReg, rdSrc;
  logic       isCmd, setCol, setRow;

  always_comb begin
    assembled = nibbleMode ? {hiNib, dataIn[3:0]} : dataIn;
    isCmd     = strobes.byteWrite & ~strobes.isData;
    setCol    = isCmd & (assembled[7:4] == 4'h1);
    setRow    = isCmd & (assembled[7:4] == 4'h2);
    addrSet   = setCol | setRow;
    cmdValid  = isCmd;
    cmdByte   = assembled;
    ramWe     = strobes.byteWrite & strobes.isData;
    ramWdata  = assembled;
    rdSrc     = strobes.isData ? readReg : statusIn;
    if (!nibbleMode)
      dataOut = rdSrc;
    else
      dataOut = {4'h0, strobes.phaseLo ? rdSrc[3:0] : rdSrc[7:4]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib   <= 4'h0;
      readReg <= 8'h00;
      ramCol  <= '0;
      ramRow  <= '0;
    end else begin
      if (strobes.hiStore)
        hiNib <= dataIn[3:0];
      if (strobes.reload)
        readReg <= ramRdata;
      if (setCol)
        ramCol <= COL_W'(assembled[3:0]);
      else if (setRow)
        ramRow <= ROW_W'(assembled[3:0]);
      else if (strobes.advance) begin
        if (ramCol == COL_LAST) begin
          ramCol <= '0;
          ramRow <= (ramRow == ROW_LAST) ? '0 : ramRow + 1'b1;
        end else begin
          ramCol <= ramCol + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_host_bus.sv
module lcd_host_bus
  import lcd_bus_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 104,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busMode,
  input  logic             nibbleMode,
  input  logic             csN,
  input  logic             cd,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             rwSel,
  input  logic             enable,
  input  logic [7:0]       dataIn,
  output logic [7:0]       dataOut,
  output logic             dataOe,
  input  logic [7:0]       statusIn,
  output logic             cmdValid,
  output logic [7:0]       cmdByte,
  output logic             ramWe,
  output logic [7:0]       ramWdata,
  output logic [COL_W-1:0] ramCol,
  output logic [ROW_W-1:0] ramRow,
  input  logic [7:0]       ramRdata
);
  bus_strobe_t strobes;
  logic        addrSet;

  lcd_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .nibbleMode(nibbleMode),
    .csN(csN), .cd(cd), .wrN(wrN), .rdN(rdN), .rwSel(rwSel),
    .enable(enable), .addrSet(addrSet), .strobes(strobes), .dataOe(dataOe)
  );

  lcd_bus_datapath #(.COLS(COLS), .ROWS(ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .nibbleMode(nibbleMode),
    .dataIn(dataIn), .statusIn(statusIn), .ramRdata(ramRdata),
    .dataOut(dataOut), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .ramWe(ramWe), .ramWdata(ramWdata), .ramCol(ramCol), .ramRow(ramRow),
    .addrSet(addrSet)
  );
endmodule

// File: rtl/lcd_host_bus_chk.sv
module lcd_host_bus_chk #(
  parameter int COLS = 80,
  parameter int ROWS = 104,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             cmdValid,
  input logic [7:0]       cmdByte,
  input logic             ramWe,
  input logic [COL_W-1:0] ramCol,
  input logic [ROW_W-1:0] ramRow
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!ramWe && !cmdValid));

  p_cmd_data_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && cmdValid));

  p_set_col_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte[7:4] == 4'h1) |=> ramCol == COL_W'($past(cmdByte[3:0])));

  p_set_row_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte[7:4] == 4'h2) |=> ramRow == ROW_W'($past(cmdByte[3:0])));

  p_col_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramCol != COL_LAST) |=> (ramCol == $past(ramCol) + 1'b1) && $stable(ramRow));

  p_col_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramCol == COL_LAST) |=>
      (ramCol == '0) && (ramRow == (($past(ramRow) == ROW_LAST) ? '0 : $past(ramRow) + 1'b1)));
endmodule

bind lcd_host_bus lcd_host_bus_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .cmdValid(cmdValid), .cmdByte(cmdByte),
  .ramWe(ramWe), .ramCol(ramCol), .ramRow(ramRow)
);

// File: tb/lcd_host_bus_tb.sv
module lcd_host_bus_tb;
  localparam int COLS = 80;
  localparam int ROWS = 104;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busMode = 1'b0, nibbleMode = 1'b0, csN = 1'b1, cd = 1'b0;
  logic wrN = 1'b1, rdN = 1'b1, rwSel = 1'b0, enable = 1'b0;
  logic [7:0] dataIn = 8'h00, statusIn = 8'hA5;
  logic [7:0] dataOut, cmdByte, ramWdata, ramRdata;
  logic dataOe, cmdValid, ramWe;
  logic [6:0] ramCol, ramRow;

  int tests = 0, fails = 0;
  bit finished = 0;

  // sampled results of the last strobe
  logic sWe, sCmd, sOe;
  logic [7:0] sWdata, sCmdByte, sRd;
  int sCol, sRow;

  always #5 clk = ~clk;

  function automatic logic [7:0] cellVal(input int c, input int r);
    return 8'((c * 3 + r * 29 + 11) & 255);
  endfunction

  assign ramRdata = cellVal(int'(ramCol), int'(ramRow));

  lcd_host_bus #(.COLS(COLS), .ROWS(ROWS)) u_dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .nibbleMode(nibbleMode),
    .csN(csN), .cd(cd), .wrN(wrN), .rdN(rdN), .rwSel(rwSel), .enable(enable),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .statusIn(statusIn),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .ramWe(ramWe), .ramWdata(ramWdata),
    .ramCol(ramCol), .ramRow(ramRow), .ramRdata(ramRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic setActive(input logic wr);
    if (busMode) begin rwSel = ~wr; enable = 1'b1; end
    else if (wr) wrN = 1'b0;
    else rdN = 1'b0;
  endtask

  task automatic release_();
    wrN = 1'b1; rdN = 1'b1; enable = 1'b0;
  endtask

  task automatic sampleOut();
    sWe = ramWe; sCmd = cmdValid; sWdata = ramWdata; sCmdByte = cmdByte;
    sCol = int'(ramCol); sRow = int'(ramRow);
  endtask

  // one write strobe; outputs sampled in the release cycle
  task automatic strobeWr(input logic cdv, input logic [7:0] d);
    @(negedge clk); cd = cdv; dataIn = d; setActive(1'b1);
    @(negedge clk);
    @(negedge clk); release_(); #1 sampleOut();
    @(negedge clk);
  endtask

  task automatic strobeRd(input logic cdv, output logic [7:0] v);
    @(negedge clk); cd = cdv; setActive(1'b0);
    @(negedge clk); #1 v = dataOut; sOe = dataOe;
    @(negedge clk); release_();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic cdv, input logic [7:0] b);
    if (nibbleMode) begin
      strobeWr(cdv, {4'h0, b[7:4]});
      strobeWr(cdv, {4'h0, b[3:0]});
    end else strobeWr(cdv, b);
  endtask

  task automatic busRead(input logic cdv, output logic [7:0] b);
    logic [7:0] h, l;
    if (nibbleMode) begin
      strobeRd(cdv, h); strobeRd(cdv, l);
      b = {h[3:0], l[3:0]};
      if (h[7:4] != 4'h0 || l[7:4] != 4'h0) b = 8'hxx;
    end else strobeRd(cdv, b);
  endtask

  task automatic setPtr(input int c, input int r);
    busWrite(1'b0, 8'h10 | 8'(c));
    chk("R7 set column command on cmdByte", {sCmd, sCmdByte}, {1'b1, 8'h10 | 8'(c)});
    busWrite(1'b0, 8'h20 | 8'(r));
    chk("R7 set row command on cmdByte", {sCmd, sCmdByte}, {1'b1, 8'h20 | 8'(r)});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    int c, r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 reset ramCol", ramCol, 0);
    chk("R11 reset ramRow", ramRow, 0);
    chk("R11 reset ramWe/cmdValid/dataOe", {ramWe, cmdValid, dataOe}, 0);
    csN = 1'b0;

    // R1 R4 R7 R10: separate strobes, 8-bit, write sweep across a column wrap
    setPtr(0, 2);
    for (int i = 0; i < 82; i++) begin
      busWrite(1'b1, 8'(i * 5 + 1));
      chk("R4 R1 data write commits", {sWe, sCmd, sWdata}, {1'b1, 1'b0, 8'(i * 5 + 1)});
      chk("R10 write column", sCol, i % COLS);
      chk("R10 write row", sRow, 2 + i / COLS);
    end

    // R3 chip select high: nothing happens
    csN = 1'b1;
    busWrite(1'b1, 8'h77);
    chk("R3 no ramWe when deselected", sWe, 0);
    busWrite(1'b0, 8'h15);
    chk("R3 no cmdValid when deselected", sCmd, 0);
    strobeRd(1'b1, v);
    chk("R3 dataOe low when deselected", sOe, 0);
    csN = 1'b0;
    busWrite(1'b1, 8'h42);
    chk("R3 pointer unchanged (column)", sCol, 2);
    chk("R3 pointer unchanged (row)", sRow, 3);

    // R1 R8: 8-bit read sweep with dummy read
    setPtr(3, 4);
    strobeRd(1'b1, v);
    chk("R1 dataOe during read", sOe, 1);
    for (int i = 0; i < 10; i++) begin
      busRead(1'b1, v);
      chk("R8 read returns pipelined memory byte", v, cellVal(3 + i, 4));
    end

    // R12: status read, 8-bit, pointer not moved
    busRead(1'b0, v);
    chk("R12 status read byte", v, 8'hA5);
    busRead(1'b1, v);
    chk("R12 status read left pointer", v, cellVal(13, 4));

    // R2 R5: enable style, 4-bit writes
    busMode = 1'b1; nibbleMode = 1'b1;
    setPtr(10, 5);
    for (int i = 0; i < 20; i++) begin
      strobeWr(1'b1, {4'h0, 4'(i)});
      chk("R5 no commit on high nibble", sWe, 0);
      strobeWr(1'b1, {4'h0, 4'(15 - i)});
      chk("R5 R2 assembled nibble byte", {sWe, sWdata}, {1'b1, 4'(i), 4'(15 - i)});
      chk("R2 write column", sCol, 10 + i);
    end

    // R10 R9: wrap during 4-bit reads, enable style
    busMode = 1'b0; nibbleMode = 1'b0;
    setPtr(15, 1);
    for (int i = 0; i < 62; i++) begin
      busWrite(1'b1, 8'(i));
      chk("R10 write column pre-read", sCol, 15 + i);
    end
    busMode = 1'b1; nibbleMode = 1'b1;
    strobeRd(1'b1, v);
    strobeRd(1'b1, v);
    for (int i = 0; i < 6; i++) begin
      c = (77 + i) % COLS; r = 1 + (77 + i) / COLS;
      busRead(1'b1, v);
      chk("R9 R10 nibble read across wrap", v, cellVal(c, r));
      if (i == 2) begin
        busRead(1'b0, v);
        chk("R12 R9 status read in nibbles", v, 8'hA5);
      end
    end

    // R6: cd toggle between nibbles resets phase
    busMode = 1'b0;
    setPtr(0, 6);
    strobeWr(1'b1, 8'h0C);
    @(negedge clk); cd = 1'b0;
    @(negedge clk); cd = 1'b1;
    @(negedge clk);
    strobeWr(1'b1, 8'h09);
    chk("R6 toggle restarted high nibble", sWe, 0);
    strobeWr(1'b1, 8'h06);
    chk("R6 byte after toggle", {sWe, sWdata}, {1'b1, 8'h96});

    // R6: cd change in the same cycle as a nibble release
    strobeWr(1'b1, 8'h0B);
    @(negedge clk); cd = 1'b1; dataIn = 8'h03; wrN = 1'b0;
    @(negedge clk);
    @(negedge clk); wrN = 1'b1; cd = 1'b0; #1 sampleOut();
    chk("R6 coincident toggle no commit", {sWe, sCmd}, 0);
    @(negedge clk);
    strobeWr(1'b0, 8'h07);
    chk("R6 coincident nibble taken as high", {sCmd, sCmdByte}, {1'b1, 8'h37});

    // R11: reset mid-byte restores phase and pointer
    strobeWr(1'b1, 8'h0E);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busWrite(1'b1, 8'h5A);
    chk("R11 byte after reset", {sWe, sWdata}, {1'b1, 8'h5A});
    chk("R11 pointer after reset", {sCol, sRow}, 0);

    summary();
  end
endmodule